// File: doc/BRIEF.md
# Multi-core IRQ/FIQ interrupt router

This block collects every interrupt source that concerns a group of four processor cores and turns it into one normal-priority (IRQ) line and one fast (FIQ) line per core. The sources are four timer lines per core, four mailbox-pending flags per core, a shared upstream IRQ and a shared upstream FIQ, and a local timer request. The local timer arrives already tagged with a target core and a kind (IRQ or FIQ) by the timer block that owns it.

For each core, a timer-control word and a mailbox-control word decide whether each of that core's timer and mailbox sources goes to FIQ, goes to IRQ or is masked. When both choices are enabled, FIQ wins. A route word names the core that receives the shared upstream IRQ and the core that receives the shared upstream FIQ. The block assembles a 12-bit source bitmap per core and per kind. Software can read these bitmaps at fixed offsets. A core's output line is high when its bitmap is nonzero, and it is registered once so that the line to the core has no glitches.

Accesses are single 32-bit words over a simple register port with an 8-bit byte address. The read data follows the address combinationally. A write takes effect at the clock edge.

Top module: `core_irq_router`

## Requirements
- R1: In each core's source bitmap, bit n (n = 0..3) is timer line n of that core and bit 4+n is mailbox n of that core. Bit 8 is the upstream interrupt and bit 11 is the local timer. Bits 9, 10 and 12..31 always read 0.
- R2: For timer or mailbox source n of a core, the core's matching control word sends an active source to FIQ when bit n+4 is set. Otherwise it sends the source to IRQ when bit n is set. Otherwise the source is masked. When both bits are set, the source appears only in the FIQ bitmap.
- R3: The route word at offset 0x0C holds the upstream-IRQ target core in bits [1:0] and the upstream-FIQ target core in bits [3:2]. A write keeps only these four bits, and a read returns them with all other bits 0. An active upstream IRQ sets bit 8 only in the IRQ bitmap of its target core, and an active upstream FIQ sets bit 8 only in the FIQ bitmap of its target core.
- R4: The timer-control word of core c is at offset 0x40+4c and the mailbox-control word of core c is at offset 0x50+4c. A write keeps the low 8 bits, and a read returns them with bits [31:8] at 0.
- R5: The IRQ bitmap of core c reads at 0x60+4c and the FIQ bitmap of core c reads at 0x70+4c. Writes to these offsets change nothing.
- R6: `core_irq[c]` equals the OR of core c's IRQ bitmap one clock earlier, and `core_fiq[c]` equals the OR of core c's FIQ bitmap one clock earlier.
- R7: Reset clears the route word and all control words to 0 and drives every output line low.
- R8: A read of any other offset, including an offset that is not a multiple of 4, returns 0. A write to such an offset changes no register.
- R9: When `ltmr_req` is high, bit 11 is set in exactly one bitmap: the FIQ bitmap of core `ltmr_core` when `ltmr_fiq` is 1, otherwise the IRQ bitmap of that core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe for the register port |
| acc_addr | input | 8 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr` (combinational) |
| tmr_lvl | input | 16 | Timer lines, four per core; bit 4c+n is line n of core c |
| mbx_lvl | input | 16 | Mailbox pending flags; bit 4c+n is mailbox n of core c |
| up_irq | input | 1 | Shared upstream IRQ level |
| up_fiq | input | 1 | Shared upstream FIQ level |
| ltmr_req | input | 1 | Local timer request level |
| ltmr_core | input | 2 | Target core of the local timer request |
| ltmr_fiq | input | 1 | 1 sends the local timer request to FIQ, 0 to IRQ |
| core_irq | output | 4 | Registered IRQ line per core |
| core_fiq | output | 4 | Registered FIQ line per core |

## Verification
The bitmap and register read-backs are valid in the same cycle as the address. A register write becomes visible in reads from the cycle after its strobe. The core lines trail the bitmaps by exactly one edge. The scoreboard's driver tags each expected item with the cycle in which it is due, and the monitor compares it at the falling edge of that cycle. For the latency case, the driver queues the old line value for the cycle in which an input changes and the new value for the following cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Bit positions inside a core's source bitmap
  localparam int GRP_SIZE = 4;
  localparam int BIT_TMR0 = 0;
  localparam int BIT_MBX0 = 4;
  localparam int BIT_UP   = 8;
  localparam int BIT_LTMR = 11;
  localparam int MAP_USED = 12;

  // Byte offsets of the register groups
  localparam logic [7:0] OFS_ROUTE = 8'h0C;
  localparam logic [7:0] OFS_TCTL  = 8'h40;
  localparam logic [7:0] OFS_MCTL  = 8'h50;
  localparam logic [7:0] OFS_ISRC  = 8'h60;
  localparam logic [7:0] OFS_FSRC  = 8'h70;

  typedef struct packed {
    logic to_fiq;
    logic to_irq;
  } steer_t;

  // Steering of one source: the upper nibble (FIQ) beats the lower one (IRQ)
  function automatic steer_t steer_pick(input logic [7:0] ctl,
                                        input logic [1:0] idx,
                                        input logic       lvl);
    steer_t s;
    s.to_fiq = lvl & ctl[{1'b1, idx}];
    s.to_irq = lvl & ctl[{1'b0, idx}] & ~ctl[{1'b1, idx}];
    return s;
  endfunction

  // Address of entry c in a per-core group
  function automatic logic [7:0] slot_addr(input logic [7:0] base, input int c);
    return base + 8'(4 * c);
  endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [DATA_W-1:0]    acc_wdata,
  input  logic [DATA_W-1:0]    irq_word [NUM_CORES],
  input  logic [DATA_W-1:0]    fiq_word [NUM_CORES],
  output logic [CORE_W-1:0]    route_irq_core,
  output logic [CORE_W-1:0]    route_fiq_core,
  output logic [7:0]           tctl [NUM_CORES],
  output logic [7:0]           mctl [NUM_CORES],
  output logic [DATA_W-1:0]    acc_rdata,
  output logic                 addr_hit
);
  import irq_router_pkg::*;

  logic [NUM_CORES-1:0] hit_t, hit_m, hit_i, hit_f;
  logic                 hit_r;
  wire                  unused_wdata_hi = ^acc_wdata[DATA_W-1:8];

  assign hit_r = (acc_addr == ADDR_W'(OFS_ROUTE));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
    assign hit_t[c] = (acc_addr == ADDR_W'(slot_addr(OFS_TCTL, c)));
    assign hit_m[c] = (acc_addr == ADDR_W'(slot_addr(OFS_MCTL, c)));
    assign hit_i[c] = (acc_addr == ADDR_W'(slot_addr(OFS_ISRC, c)));
    assign hit_f[c] = (acc_addr == ADDR_W'(slot_addr(OFS_FSRC, c)));
  end

  assign addr_hit = hit_r | (|hit_t) | (|hit_m) | (|hit_i) | (|hit_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_irq_core <= '0;
      route_fiq_core <= '0;
      for (int c = 0; c < NUM_CORES; c++) begin
        tctl[c] <= '0;
        mctl[c] <= '0;
      end
    end else if (acc_wr) begin
      if (hit_r) begin
        route_irq_core <= acc_wdata[CORE_W-1:0];
        route_fiq_core <= acc_wdata[2*CORE_W-1:CORE_W];
      end
      for (int c = 0; c < NUM_CORES; c++) begin
        if (hit_t[c]) tctl[c] <= acc_wdata[7:0];
        if (hit_m[c]) mctl[c] <= acc_wdata[7:0];
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (hit_r) acc_rdata = DATA_W'({route_fiq_core, route_irq_core});
    for (int c = 0; c < NUM_CORES; c++) begin
      if (hit_t[c]) acc_rdata = DATA_W'(tctl[c]);
      if (hit_m[c]) acc_rdata = DATA_W'(mctl[c]);
      if (hit_i[c]) acc_rdata = irq_word[c];
      if (hit_f[c]) acc_rdata = fiq_word[c];
    end
  end

endmodule

// File: rtl/irq_router_steer.sv
module irq_router_steer #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int DATA_W    = 32
) (
  input  logic [NUM_CORES*4-1:0] tmr_lvl,
  input  logic [NUM_CORES*4-1:0] mbx_lvl,
  input  logic                   up_irq,
  input  logic                   up_fiq,
  input  logic [CORE_W-1:0]      route_irq_core,
  input  logic [CORE_W-1:0]      route_fiq_core,
  input  logic [7:0]             tctl [NUM_CORES],
  input  logic [7:0]             mctl [NUM_CORES],
  input  logic                   ltmr_req,
  input  logic [CORE_W-1:0]      ltmr_core,
  input  logic                   ltmr_fiq,
  output logic [DATA_W-1:0]      irq_word [NUM_CORES],
  output logic [DATA_W-1:0]      fiq_word [NUM_CORES]
);
  import irq_router_pkg::*;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [GRP_SIZE-1:0] t_irq, t_fiq, m_irq, m_fiq;
    logic                up_i, up_f, lt_i, lt_f, lt_here;

    for (genvar n = 0; n < GRP_SIZE; n++) begin : g_src
      steer_t ts, ms;
      assign ts = steer_pick(tctl[c], 2'(n), tmr_lvl[c*GRP_SIZE+n]);
      assign ms = steer_pick(mctl[c], 2'(n), mbx_lvl[c*GRP_SIZE+n]);
      assign t_irq[n] = ts.to_irq;
      assign t_fiq[n] = ts.to_fiq;
      assign m_irq[n] = ms.to_irq;
      assign m_fiq[n] = ms.to_fiq;
    end

    assign up_i    = up_irq & (route_irq_core == CORE_W'(c));
    assign up_f    = up_fiq & (route_fiq_core == CORE_W'(c));
    assign lt_here = ltmr_req & (ltmr_core == CORE_W'(c));
    assign lt_i    = lt_here & ~ltmr_fiq;
    assign lt_f    = lt_here & ltmr_fiq;

    assign irq_word[c] = DATA_W'({lt_i, 2'b00, up_i, m_irq, t_irq});
    assign fiq_word[c] = DATA_W'({lt_f, 2'b00, up_f, m_fiq, t_fiq});
  end

endmodule

// File: rtl/irq_router_outreg.sv
module irq_router_outreg #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    irq_word [NUM_CORES],
  input  logic [DATA_W-1:0]    fiq_word [NUM_CORES],
  output logic [NUM_CORES-1:0] irq_any,
  output logic [NUM_CORES-1:0] fiq_any,
  output logic [NUM_CORES-1:0] core_irq,
  output logic [NUM_CORES-1:0] core_fiq
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_any
    assign irq_any[c] = |irq_word[c];
    assign fiq_any[c] = |fiq_word[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_irq <= '0;
      core_fiq <= '0;
    end else begin
      core_irq <= irq_any;
      core_fiq <= fiq_any;
    end
  end

endmodule

// File: rtl/core_irq_router.sv
module core_irq_router #(
  parameter  int NUM_CORES = 4,
  parameter  int ADDR_W    = 8,
  parameter  int DATA_W    = 32,
  localparam int CORE_W    = $clog2(NUM_CORES),
  localparam int LINES     = NUM_CORES * 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [DATA_W-1:0]    acc_wdata,
  output logic [DATA_W-1:0]    acc_rdata,
  input  logic [LINES-1:0]     tmr_lvl,
  input  logic [LINES-1:0]     mbx_lvl,
  input  logic                 up_irq,
  input  logic                 up_fiq,
  input  logic                 ltmr_req,
  input  logic [CORE_W-1:0]    ltmr_core,
  input  logic                 ltmr_fiq,
  output logic [NUM_CORES-1:0] core_irq,
  output logic [NUM_CORES-1:0] core_fiq
);

  logic [CORE_W-1:0]    route_irq_core, route_fiq_core;
  logic [7:0]           tctl [NUM_CORES];
  logic [7:0]           mctl [NUM_CORES];
  logic [DATA_W-1:0]    irq_word [NUM_CORES];
  logic [DATA_W-1:0]    fiq_word [NUM_CORES];
  logic [NUM_CORES-1:0] irq_any, fiq_any;
  logic                 addr_hit;

  irq_router_regs #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .irq_word(irq_word), .fiq_word(fiq_word),
    .route_irq_core(route_irq_core), .route_fiq_core(route_fiq_core),
    .tctl(tctl), .mctl(mctl), .acc_rdata(acc_rdata), .addr_hit(addr_hit)
  );

  irq_router_steer #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .DATA_W(DATA_W)
  ) steer_i (
    .tmr_lvl(tmr_lvl), .mbx_lvl(mbx_lvl), .up_irq(up_irq), .up_fiq(up_fiq),
    .route_irq_core(route_irq_core), .route_fiq_core(route_fiq_core),
    .tctl(tctl), .mctl(mctl), .ltmr_req(ltmr_req), .ltmr_core(ltmr_core),
    .ltmr_fiq(ltmr_fiq), .irq_word(irq_word), .fiq_word(fiq_word)
  );

  irq_router_outreg #(
    .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)
  ) outreg_i (
    .clk(clk), .rst_n(rst_n), .irq_word(irq_word), .fiq_word(fiq_word),
    .irq_any(irq_any), .fiq_any(fiq_any),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DATA_W-1:0]    acc_rdata,
  input logic                 addr_hit,
  input logic [DATA_W-1:0]    irq_word [NUM_CORES],
  input logic [DATA_W-1:0]    fiq_word [NUM_CORES],
  input logic [NUM_CORES-1:0] irq_any,
  input logic [NUM_CORES-1:0] fiq_any,
  input logic                 up_irq,
  input logic                 up_fiq,
  input logic                 ltmr_req,
  input logic [NUM_CORES-1:0] core_irq,
  input logic [NUM_CORES-1:0] core_fiq
);

  logic [NUM_CORES-1:0] up_i_col, up_f_col, lt_col_i, lt_col_f;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assign up_i_col[c] = irq_word[c][8];
    assign up_f_col[c] = fiq_word[c][8];
    assign lt_col_i[c] = irq_word[c][11];
    assign lt_col_f[c] = fiq_word[c][11];

    // R6: each line trails its bitmap by one edge
    p_irq_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> core_irq[c] == $past(irq_any[c]));
    p_fiq_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> core_fiq[c] == $past(fiq_any[c]));

    // R2: a timer or mailbox source never sits in both bitmaps
    p_fiq_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_word[c][7:0] & fiq_word[c][7:0]) == 8'h00);

    // R1: unused bitmap positions stay clear
    p_spare_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_word[c][DATA_W-1:12] == '0 && irq_word[c][10:9] == 2'b00 &&
      fiq_word[c][DATA_W-1:12] == '0 && fiq_word[c][10:9] == 2'b00);
  end

  // R3: the upstream lines land on exactly one core each
  p_up_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(up_i_col) == int'(up_irq) && $countones(up_f_col) == int'(up_fiq));

  // R9: the local timer lands in exactly one bitmap
  p_ltmr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lt_col_i, lt_col_f}) == int'(ltmr_req));

  // R8: unmapped offsets read as zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> acc_rdata == '0);

endmodule

bind core_irq_router irq_router_chk #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_rdata(acc_rdata), .addr_hit(addr_hit),
  .irq_word(irq_word), .fiq_word(fiq_word), .irq_any(irq_any),
  .fiq_any(fiq_any), .up_irq(up_irq), .up_fiq(up_fiq), .ltmr_req(ltmr_req),
  .core_irq(core_irq), .core_fiq(core_fiq)
);

// File: tb/core_irq_router_tb_top.sv
module core_irq_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic [7:0]  acc_addr = 8'h00;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [15:0] tmr_lvl = '0;
  logic [15:0] mbx_lvl = '0;
  logic        up_irq = 1'b0, up_fiq = 1'b0;
  logic        ltmr_req = 1'b0, ltmr_fiq = 1'b0;
  logic [1:0]  ltmr_core = 2'd0;
  logic [3:0]  core_irq, core_fiq;

  // 250 MHz: 4 time units per period
  always #2 clk = ~clk;

  core_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .tmr_lvl(tmr_lvl),
    .mbx_lvl(mbx_lvl), .up_irq(up_irq), .up_fiq(up_fiq), .ltmr_req(ltmr_req),
    .ltmr_core(ltmr_core), .ltmr_fiq(ltmr_fiq),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

  typedef struct {
    int          due;
    bit          is_line;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // Bench-side copy of the programmable state
  logic [3:0] sh_route = '0;
  logic [7:0] sh_t [4];
  logic [7:0] sh_m [4];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares each queued item at the falling edge of its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_line ? {24'h0, core_fiq, core_irq} : acc_rdata;
      checks++;
      if (it.due != cyc || act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h (cycle %0d, due %0d)",
                 it.tag, act, it.exp, cyc, it.due);
      end
    end
  end

  // Independent restatement of the bitmaps from the requirements
  function automatic logic [31:0] mdl(input int c, input bit want_fiq);
    logic [31:0] w = '0;
    for (int n = 0; n < 4; n++) begin
      if (tmr_lvl[c*4+n]) begin
        if (sh_t[c][n+4]) w[n] = want_fiq;
        else if (sh_t[c][n]) w[n] = !want_fiq;
      end
      if (mbx_lvl[c*4+n]) begin
        if (sh_m[c][n+4]) w[n+4] = want_fiq;
        else if (sh_m[c][n]) w[n+4] = !want_fiq;
      end
    end
    if (!want_fiq && up_irq && int'(sh_route[1:0]) == c) w[8] = 1'b1;
    if (want_fiq && up_fiq && int'(sh_route[3:2]) == c) w[8] = 1'b1;
    if (ltmr_req && int'(ltmr_core) == c && ltmr_fiq == want_fiq) w[11] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] lines_exp();
    logic [31:0] v = '0;
    for (int c = 0; c < 4; c++) begin
      v[c]   = |mdl(c, 1'b0);
      v[c+4] = |mdl(c, 1'b1);
    end
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    tick();
    acc_wr = 1'b0;
    if (a == 8'h0C) sh_route = d[3:0];
    for (int c = 0; c < 4; c++) begin
      if (a == 8'(8'h40 + 4*c)) sh_t[c] = d[7:0];
      if (a == 8'(8'h50 + 4*c)) sh_m[c] = d[7:0];
    end
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    acc_addr = a;
    q.push_back('{due: cyc, is_line: 1'b0, exp: e, tag: tag});
    tick();
  endtask

  task automatic chk_lines(input logic [31:0] e, input int lag, input string tag);
    q.push_back('{due: cyc + lag, is_line: 1'b1, exp: e, tag: tag});
  endtask

  task automatic chk_all(input string tag);
    for (int c = 0; c < 4; c++) begin
      chk_rd(8'(8'h60 + 4*c), mdl(c, 1'b0), {tag, " irq bitmap"});
      chk_rd(8'(8'h70 + 4*c), mdl(c, 1'b1), {tag, " fiq bitmap"});
    end
    chk_lines(lines_exp(), 0, {tag, " lines R6"});
    tick();
  endtask

  task automatic chk_regs(input string tag);
    chk_rd(8'h0C, {28'h0, sh_route}, {tag, " route R3"});
    for (int c = 0; c < 4; c++) begin
      chk_rd(8'(8'h40 + 4*c), {24'h0, sh_t[c]}, {tag, " timer ctl R4"});
      chk_rd(8'(8'h50 + 4*c), {24'h0, sh_m[c]}, {tag, " mailbox ctl R4"});
    end
  endtask

  initial begin
    logic [31:0] prev;
    for (int c = 0; c < 4; c++) begin sh_t[c] = '0; sh_m[c] = '0; end
    repeat (3) tick();

    // R7: state and lines while in reset and right after release
    chk_lines(32'h0, 0, "R7 lines in reset");
    tick();
    rst_n = 1'b1;
    tick();
    chk_regs("R7 after reset");
    chk_all("R7 idle");

    // R3: route keeps four bits
    wr(8'h0C, 32'hFFFF_FFF6);
    chk_rd(8'h0C, 32'h0000_0006, "R3 route masked");
    // R4: control words keep the low byte
    wr(8'h40, 32'h1234_5631);
    wr(8'h5C, 32'hFFFF_FF0F);
    chk_rd(8'h40, 32'h0000_0031, "R4 timer ctl core0");
    chk_rd(8'h5C, 32'h0000_000F, "R4 mailbox ctl core3");

    // R3 + R6 latency: upstream IRQ to core 2, upstream FIQ to core 1
    prev = lines_exp();
    up_irq = 1'b1;
    chk_lines(prev, 0, "R6 old value in change cycle");
    chk_lines(lines_exp(), 1, "R6 new value next cycle");
    tick(); tick();
    chk_rd(8'h68, 32'h0000_0100, "R3 upstream irq on core2");
    up_fiq = 1'b1;
    chk_rd(8'h74, 32'h0000_0100, "R3 upstream fiq on core1");
    chk_all("R3 upstream");

    // R2: core0 timer ctl 0x31: line0 both bits -> FIQ, line1 -> FIQ, 2/3 masked
    tmr_lvl[3:0] = 4'hF;
    chk_rd(8'h70, 32'h0000_0003, "R2 fiq priority core0");
    chk_rd(8'h60, 32'h0000_0000, "R2 masked and preempted core0");
    // R1: mailboxes land in bits 4..7
    mbx_lvl[15:12] = 4'hF;
    chk_rd(8'h6C, 32'h0000_00F0, "R1 mailbox bits core3");
    chk_all("R1 R2 mix");

    // R9: local timer steering
    ltmr_req = 1'b1; ltmr_core = 2'd1; ltmr_fiq = 1'b0;
    chk_rd(8'h64, 32'h0000_0800, "R9 local timer irq core1");
    ltmr_fiq = 1'b1;
    chk_rd(8'h74, 32'h0000_0900, "R9 local timer fiq core1");
    chk_all("R9 local timer");

    // R5: writes to bitmap offsets change nothing
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h74, 32'h0000_0000);
    chk_all("R5 read-only bitmaps");
    chk_regs("R5 regs untouched");

    // R8: unmapped and unaligned offsets
    chk_rd(8'h00, 32'h0, "R8 unmapped 0x00");
    chk_rd(8'h10, 32'h0, "R8 unmapped 0x10");
    chk_rd(8'h41, 32'h0, "R8 unaligned 0x41");
    chk_rd(8'hC0, 32'h0, "R8 unmapped 0xC0");
    wr(8'h0D, 32'hFFFF_FFFF);
    wr(8'h42, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    chk_regs("R8 write ignored");

    // Mixed random patterns
    for (int i = 0; i < 40; i++) begin
      tmr_lvl = 16'($urandom); mbx_lvl = 16'($urandom);
      up_irq = 1'($urandom); up_fiq = 1'($urandom);
      ltmr_req = 1'($urandom); ltmr_core = 2'($urandom); ltmr_fiq = 1'($urandom);
      if (i % 3 == 0) wr(8'(8'h40 + 4*($urandom % 4)), $urandom);
      if (i % 3 == 1) wr(8'(8'h50 + 4*($urandom % 4)), $urandom);
      if (i % 5 == 2) wr(8'h0C, $urandom);
      chk_all("R1 R2 R6 R9 random");
    end
    chk_regs("R3 R4 random end");

    // R7: reset in the middle of activity
    up_irq = 1'b1; tmr_lvl = 16'hFFFF;
    rst_n = 1'b0;
    sh_route = '0;
    for (int c = 0; c < 4; c++) begin sh_t[c] = '0; sh_m[c] = '0; end
    #0;
    chk_lines(32'h0, 0, "R7 lines cleared by reset");
    tick();
    rst_n = 1'b1;
    chk_regs("R7 regs cleared");
    chk_all("R7 after second reset");

    repeat (3) tick();
    done = 1'b1;
  end

  initial begin
    wait (done);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL all: scoreboard left actual=%0d expected=0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all: watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule